// File: doc/BRIEF.md
# Dual-Mode Bus Arbiter

This block decides which of eight bus masters owns a shared bus in the next cycle. Each cycle it looks at the request vector and registers a one-hot grant. A mode input selects between two schemes. In rotating mode, service moves around the ring 0 → 1 → … → 7 → 0, starting just past the last master that was served. In ranked mode, every master carries a 3-bit code in a packed 24-bit vector, and the lowest code wins. When several masters share the lowest code, the lowest index wins.

The mode bit can change in any cycle. The rotation pointer is frozen while ranked mode is in use, so rotating service picks up where it left off. The reset input is active-low. Asserting it clears the grant and the pointer at once, with no clock edge needed. Its release passes through a two-stage synchronizer, so grants resume on the third rising edge after the release.

Top module: `arb_dual`

## Requirements
- R1: The grant output has at most one bit set in every cycle.
- R2: A request vector of all zeros sampled at an edge gives an all-zero grant after that edge.
- R3: The grant is registered. It changes only at a rising clock edge and reflects the request, code and mode values sampled at that edge. A change on the inputs between edges leaves the grant unchanged until the next edge.
- R4: In rotating mode (mode bit 0), the search starts at the index one above the last granted master and wraps from 7 to 0. The first active request found is granted. After reset the search starts at index 0.
- R5: The rotation pointer moves only when a grant is issued in rotating mode. Cycles in ranked mode or with no requests leave it unchanged.
- R6: In ranked mode (mode bit 1), master n takes its code from prio_i[3n+2:3n]. The active master with the numerically smallest code is granted.
- R7: In ranked mode, when several active masters share the smallest code, the lowest-numbered one among them is granted.
- R8: A single active request is granted at the next edge in either mode.
- R9: A change of the mode bit takes effect at the next rising edge.
- R10: Driving rst_ni low clears the grant at once, without a clock edge. After rst_ni rises, the grant stays zero for two rising edges and the first grant appears after the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| mode_i | input | 1 | 0 = rotating service, 1 = ranked service |
| req_i | input | 8 | One request bit per master |
| prio_i | input | 24 | Packed 3-bit codes; master n uses bits [3n+2:3n] |
| gnt_o | output | 8 | Registered one-hot grant |

## Verification
Rotating mode is swept over all 256 request patterns twice, so that each pattern meets many pointer positions. A bench model computes the expected winner by rotating the request vector. This separates a correct wrap and starting point from an off-by-one in the pointer. Ranked mode is swept over all 256 patterns with several hashed code sets, which checks that the codes are read from the right field. Further sweeps give every master the same code, so that only the tie-break decides the winner. Directed sequences cover the following:
- interleaving the two modes, to show that the pointer is preserved;
- single requests and the empty request;
- the timing of reset assertion and release.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    ARB_ROTATE = 1'b0,
    ARB_RANK   = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/arb_rst_sync.sv
// Asynchronous assertion, synchronous release.
module arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/arb_rot_pick.sv
// Rotating search: first active request above the last served index, wrapping.
module arb_rot_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(last_i) + k) % N;
      if (!any_o && req_i[j]) begin
        any_o    = 1'b1;
        gnt_o[j] = 1'b1;
        idx_o    = IW'(j);
      end
    end
  end
endmodule

// File: rtl/arb_rank_pick.sv
// Ranked search: smallest code wins, lowest index on equal codes.
module arb_rank_pick #(
  parameter int N  = 8,
  parameter int PW = 3
) (
  input  logic [N-1:0]    req_i,
  input  logic [N*PW-1:0] prio_i,
  output logic [N-1:0]    gnt_o
);
  logic [PW-1:0] best;
  logic          found;

  always_comb begin
    gnt_o = '0;
    best  = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      logic [PW-1:0] code;
      code = prio_i[i*PW +: PW];
      if (req_i[i] && (!found || code < best)) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        best     = code;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_dual.sv
module arb_dual
  import arb_pkg::*;
#(
  parameter int N  = 8,
  parameter int PW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_i,
  input  logic [N-1:0]    req_i,
  input  logic [N*PW-1:0] prio_i,
  output logic [N-1:0]    gnt_o
);
  localparam int IW = $clog2(N);
  localparam logic [IW-1:0] PTR_RST = IW'(N - 1);

  logic            rst_n_q;
  logic [N-1:0]    rot_gnt, rank_gnt, gnt_d, gnt_q;
  logic [IW-1:0]   rot_idx, ptr_d, ptr_q;
  logic            rot_any, ptr_en;
  arb_mode_e       mode;

  arb_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_q)
  );

  arb_rot_pick #(.N(N), .IW(IW)) u_rot (
    .req_i (req_i),
    .last_i(ptr_q),
    .gnt_o (rot_gnt),
    .idx_o (rot_idx),
    .any_o (rot_any)
  );

  arb_rank_pick #(.N(N), .PW(PW)) u_rank (
    .req_i (req_i),
    .prio_i(prio_i),
    .gnt_o (rank_gnt)
  );

  // Next-state logic
  always_comb begin
    mode   = arb_mode_e'(mode_i);
    gnt_d  = (mode == ARB_RANK) ? rank_gnt : rot_gnt;
    ptr_en = (mode == ARB_ROTATE) && rot_any;
    ptr_d  = rot_idx;
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      gnt_q <= '0;
      ptr_q <= PTR_RST;
    end else begin
      gnt_q <= gnt_d;
      if (ptr_en) ptr_q <= ptr_d;
    end
  end

  assign gnt_o = gnt_q;
endmodule

// File: rtl/arb_dual_chk.sv
module arb_dual_chk #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode,
  input logic [N-1:0]  req,
  input logic [N-1:0]  gnt,
  input logic [IW-1:0] ptr
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R1
  onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R2
  idle_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && req == '0) |=> (gnt == '0));

  // R3
  gnt_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> ((gnt & ~$past(req)) == '0));

  // R3
  busy_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && req != '0) |=> ($countones(gnt) == 1));

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && mode) |=> $stable(ptr));

  // R8
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $onehot(req)) |=> (gnt == $past(req)));
endmodule

bind arb_dual arb_dual_chk #(.N(N), .IW(IW)) u_chk (
  .clk  (clk_i),
  .rst_n(rst_n_q),
  .mode (mode_i),
  .req  (req_i),
  .gnt  (gnt_q),
  .ptr  (ptr_q)
);

// File: tb/test_arb_dual.sv
module test_arb_dual;
  localparam int N  = 8;
  localparam int PW = 3;

  logic            clk;
  logic            rst_n;
  logic            mode;
  logic [N-1:0]    req;
  logic [N*PW-1:0] prio;
  logic [N-1:0]    gnt;

  int  total = 0;
  int  bad   = 0;
  int  mptr  = N - 1;
  bit  done  = 0;

  arb_dual #(.N(N), .PW(PW)) i_arb_dual (
    .clk_i (clk),
    .rst_ni(rst_n),
    .mode_i(mode),
    .req_i (req),
    .prio_i(prio),
    .gnt_o (gnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Rotate the request vector so that index mptr+1 lands at bit 0, then take the lowest set bit.
  function automatic int exp_rot(input logic [N-1:0] r, input int p);
    logic [2*N-1:0] dbl;
    logic [N-1:0]   rot;
    int sh;
    sh  = (p + 1) % N;
    dbl = {r, r} >> sh;
    rot = dbl[N-1:0];
    for (int b = 0; b < N; b++)
      if (rot[b]) return (b + sh) % N;
    return -1;
  endfunction

  // The smallest key code*N + index decides the winner.
  function automatic int exp_rank(input logic [N-1:0] r, input logic [N*PW-1:0] p);
    int best, win;
    best = 1 << 30;
    win  = -1;
    for (int i = 0; i < N; i++) begin
      int key;
      key = int'(p[i*PW +: PW]) * N + i;
      if (r[i] && key < best) begin
        best = key;
        win  = i;
      end
    end
    return win;
  endfunction

  // Called at a negedge: apply inputs, check hold, cross one edge, check the grant.
  task automatic step(input logic m, input logic [N-1:0] r,
                      input logic [N*PW-1:0] p, input string tag);
    logic [N-1:0] prev, exp;
    int w;
    prev = gnt;
    mode = m;
    req  = r;
    prio = p;
    #1;
    chk(gnt == prev, "R3", gnt, prev);
    w   = m ? exp_rank(r, p) : exp_rot(r, mptr);
    exp = (w < 0) ? '0 : (N'(1) << w);
    @(posedge clk);
    @(negedge clk);
    chk(gnt == exp, tag, gnt, exp);
    chk($countones(gnt) <= 1, "R1", gnt, exp);
    if (!m && w >= 0) mptr = w;
  endtask

  function automatic string pick_tag(input logic m, input logic [N-1:0] r);
    if (r == '0)            return "R2";
    if ($countones(r) == 1) return "R8";
    return m ? "R6" : "R4";
  endfunction

  function automatic logic [N*PW-1:0] hash_codes(input int r, input int s);
    logic [31:0] h;
    h = 32'(r) * 32'h9E3779B1 + 32'(s) * 32'h7F4A7C15;
    h = h ^ (h >> 13);
    return h[N*PW-1:0];
  endfunction

  function automatic logic [N*PW-1:0] flat_codes(input int c);
    logic [N*PW-1:0] v;
    for (int i = 0; i < N; i++) v[i*PW +: PW] = PW'(c);
    return v;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mode  = 1'b0;
    req   = '1;
    prio  = '0;
    #2;
    chk(gnt == '0, "R10", gnt, '0);
    repeat (3) @(negedge clk);
    chk(gnt == '0, "R10", gnt, '0);
    #2 rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(gnt == '0, "R10", gnt, '0);
    @(posedge clk); @(negedge clk);
    chk(gnt == '0, "R10", gnt, '0);
    @(posedge clk); @(negedge clk);
    chk(gnt == 8'h01, "R4", gnt, 8'h01);
    mptr = 0;

    // Full ring with every master requesting, including the wrap from 7 to 0.
    for (int k = 0; k < 10; k++) step(1'b0, '1, '0, "R4");

    // The pointer is kept across ranked cycles.
    step(1'b0, 8'h04, '0, "R8");
    step(1'b1, '1, flat_codes(0), "R7");
    step(1'b1, 8'hF0, hash_codes(3, 1), "R6");
    step(1'b0, '1, '0, "R5");
    step(1'b0, '0, '0, "R2");
    step(1'b0, '1, '0, "R5");

    // A mode switch takes effect at the next edge.
    step(1'b1, 8'h81, {3'd0, {(N-2)*PW{1'b1}}, 3'd5}, "R9");
    step(1'b0, 8'h81, {3'd0, {(N-2)*PW{1'b1}}, 3'd5}, "R9");
    step(1'b1, 8'h81, {3'd0, {(N-2)*PW{1'b1}}, 3'd5}, "R9");

    // Sweeps in rotating mode
    for (int pass = 0; pass < 2; pass++)
      for (int r = 0; r < 256; r++)
        step(1'b0, N'(r), '0, pick_tag(1'b0, N'(r)));

    // Sweeps in ranked mode
    for (int s = 0; s < 4; s++)
      for (int r = 0; r < 256; r++)
        step(1'b1, N'(r), hash_codes(r, s), pick_tag(1'b1, N'(r)));

    // Tie-break sweeps
    for (int c = 0; c < 8; c++)
      for (int r = 1; r < 256; r += 7)
        step(1'b1, N'(r), flat_codes(c), "R7");

    // Asynchronous assertion in the middle of a run
    step(1'b0, '1, '0, "R4");
    #2 rst_n = 1'b0;
    #1 chk(gnt == '0, "R10", gnt, '0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule